// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block stands between a host and a battery-backed static memory array. It watches two digital supply flags from an external comparator: one for power failure and one for a supply below the switch-over level. It also watches the host chip-enable, write-enable and output-enable strobes, all active low. While the supply is good, the block passes the host strobes through to the array and drives the data-output enable for read cycles.

When the supply fails, the block stops accepting new accesses. An access that was already running may still finish, but only until a bounded write-protect timeout runs out. After that, protection is forced. While protected, every strobe to the array is inactive and the data outputs are high impedance, whatever the host does.

On power-up, protection is held through a long recovery window. If the supply fails again inside that window, the whole sequence starts over. The block also drives a battery-select signal that follows the switch-over flag. It keeps the battery isolated from reset until the supply is first seen valid. Both durations are parameters counted in timebase clocks, and both supply flags are synchronized before use.

Top module: `pfwp_ctrl`

## Requirements
- R1: During and after reset, before the supply has been seen valid, all three array strobes are high, `dq_oe` is 0, `bat_iso` is 1 and `bat_sel` is 0.
- R2: While open, each array strobe equals its host strobe. `dq_oe` is 1 exactly when the host makes a read, meaning chip-enable low, write-enable high and output-enable low. It is 0 in standby, in a write and with the output disabled.
- R3: With no access in progress, protection takes effect on the third rising clock edge after `pwr_fail` rises. The synchronizer accounts for two edges and the state register for one.
- R4: A write (chip-enable and write-enable low) or a read (chip-enable and output-enable low, write-enable high) in progress when the failure is seen continues to the array. When its own strobe or chip-enable rises, the array strobes go inactive in the same cycle, and the block is protected from the next edge on.
- R5: A drained access that is still running `WPT_CYC` clock edges after the block enters the drain phase is cut off. The array strobes go inactive on that edge.
- R6: During the drain phase only the strobe of the access kind that was captured is passed. A second strobe, or a restart after the access has ended, never reaches the array.
- R7: While protected, and during recovery, the host strobes are ignored. The array strobes stay high and `dq_oe` stays 0.
- R8: After `pwr_fail` falls, the array strobes follow the host again on exactly the `REC_CYC + 3`-th rising edge, and not one edge earlier.
- R9: A power failure during the recovery window returns the block to protection. Once the supply falls valid again, the full `REC_CYC` window runs anew.
- R10: `bat_iso` is 1 from reset. It falls on the third edge after `pwr_fail` is first low and never rises again, even if power fails later.
- R11: Once isolation is cleared, `bat_sel` equals the switch-over flag delayed by two rising edges. While isolated, `bat_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Supply out of tolerance flag, asynchronous, 1 = failed |
| below_swo | input | 1 | Supply below the switch-over level, asynchronous |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| dq_oe | output | 1 | Data output driver enable, 0 = high impedance |
| bat_sel | output | 1 | Selects the backup cell as array supply |
| bat_iso | output | 1 | Backup cell isolated from the array |

## Verification
Each result has a fixed latency from its stimulus.
- Strobe gating is combinational, so a host strobe change during open operation or drain shows in the same cycle.
- Supply-flag effects on protection and on `bat_iso` arrive on the third edge.
- `bat_sel` follows after two edges.
- Release after power-up comes on edge `REC_CYC + 3`.
- The drain cut-off lands `WPT_CYC` edges after the drain phase begins.

The bench drives inputs just after a rising edge. For each expected value it records the exact edge count at which that value is due. It compares only at the falling edge of that cycle, and where the exact boundary matters it samples the cycle just before the edge as well as the edge itself.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

   // Protection sequencer states
   typedef enum logic [1:0] {
      PS_GUARD   = 2'd0,   // protected, waiting for valid supply
      PS_RECOVER = 2'd1,   // supply valid, recovery window running
      PS_OPEN    = 2'd2,   // normal host operation
      PS_DRAIN   = 2'd3    // supply failed, in-flight access finishing
   } prot_state_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

   function automatic logic is_write(input strobe_t s);
      return !s.ce_n && !s.we_n;
   endfunction

   function automatic logic is_read(input strobe_t s);
      return !s.ce_n && s.we_n && !s.oe_n;
   endfunction

endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("pfwp_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("pfwp_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate
   import pfwp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  prot_state_e state,
   input  logic        drain_wr,
   input  strobe_t     host,
   output strobe_t     mem,
   output logic        dq_oe,
   output logic        host_acc,
   output logic        host_wr,
   output logic        cont
);

   logic host_rd;

   assign host_wr  = is_write(host);
   assign host_rd  = is_read(host);
   assign host_acc = host_wr || host_rd;

   // The captured access continues only while chip enable and its own strobe stay low
   assign cont = !host.ce_n && (drain_wr ? !host.we_n : (host.we_n && !host.oe_n));

   always_comb begin
      mem   = STROBE_IDLE;
      dq_oe = 1'b0;
      unique case (state)
         PS_OPEN: begin
            mem   = host;
            dq_oe = host_rd;
         end
         PS_DRAIN: begin
            if (cont) begin
               mem.ce_n = 1'b0;
               mem.we_n = !drain_wr;
               mem.oe_n = drain_wr;
               dq_oe    = !drain_wr;
            end
         end
         default: begin
            mem   = STROBE_IDLE;
            dq_oe = 1'b0;
         end
      endcase
   end

   // R2: data drivers are on only during a read cycle seen at the array
   assert_dq_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!mem.ce_n && mem.we_n && !mem.oe_n));

   // R6: while draining, a write strobe reaches the array only for a captured write
   assert_no_new_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DRAIN && !mem.we_n) |-> drain_wr);

endmodule

// File: rtl/pfwp_sequencer.sv
module pfwp_sequencer
   import pfwp_pkg::*;
#(
   parameter int WPT_CYC = 100,
   parameter int REC_CYC = 80000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fail_s,
   input  logic        host_acc,
   input  logic        host_wr,
   input  logic        cont,
   output prot_state_e state,
   output logic        drain_wr
);

   localparam int MAX_CYC = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(WPT_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

   prot_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             wr_q, wr_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      wr_d    = wr_q;
      unique case (state_q)
         PS_GUARD: begin
            if (!fail_s) begin
               state_d = PS_RECOVER;
               cnt_d   = '0;
            end
         end
         PS_RECOVER: begin
            if (fail_s) begin
               state_d = PS_GUARD;
               cnt_d   = '0;
            end else if (cnt_q == REC_LAST) begin
               state_d = PS_OPEN;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PS_OPEN: begin
            if (fail_s) begin
               cnt_d = '0;
               if (host_acc) begin
                  state_d = PS_DRAIN;
                  wr_d    = host_wr;
               end else begin
                  state_d = PS_GUARD;
               end
            end
         end
         PS_DRAIN: begin
            if (!cont || cnt_q == WPT_LAST) begin
               state_d = PS_GUARD;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            state_d = PS_GUARD;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_GUARD;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         wr_q    <= wr_d;
      end
   end

   assign state    = state_q;
   assign drain_wr = wr_q;

   // R5: the drain phase never outlives the write-protect timeout
   assert_drain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_DRAIN) |-> (cnt_q < CNT_W'(WPT_CYC)));

   // R3: a seen failure always closes open operation on the next edge
   assert_fail_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_OPEN && fail_s) |=> (state_q != PS_OPEN));

   // R9: a failure during recovery returns to guard
   assert_recover_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RECOVER && fail_s) |=> (state_q == PS_GUARD));

   // R8: open operation is entered only from a completed recovery window
   assert_open_after_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == PS_OPEN) |-> ($past(state_q) == PS_RECOVER && $past(cnt_q) == REC_LAST));

endmodule

// File: rtl/pfwp_battery.sv
module pfwp_battery (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_s,
   input  logic swo_s,
   output logic bat_sel,
   output logic bat_iso
);

   logic iso_q;

   // Isolation is sticky-clear: once valid supply has been seen, it never returns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       iso_q <= 1'b1;
      else if (!fail_s) iso_q <= 1'b0;
   end

   assign bat_iso = iso_q;
   assign bat_sel = swo_s && !iso_q;

   // R10: isolation never re-asserts after release
   assert_iso_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(bat_iso));

   // R11: the cell is never selected while still isolated
   assert_sel_isolated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bat_iso |-> !bat_sel);

endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
   import pfwp_pkg::*;
#(
   parameter int WPT_CYC         = 100,
   parameter int REC_CYC         = 80000,
   parameter int SYNC_STAGES     = 2,
   parameter int CLK_KHZ         = 1000,
   parameter bit ENFORCE_WINDOWS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_fail,
   input  logic below_swo,
   input  logic host_ce_n,
   input  logic host_we_n,
   input  logic host_oe_n,
   output logic mem_ce_n,
   output logic mem_we_n,
   output logic mem_oe_n,
   output logic dq_oe,
   output logic bat_sel,
   output logic bat_iso
);

   initial begin
      assert (WPT_CYC >= 1 && REC_CYC >= 1)
         else $error("pfwp_ctrl: durations must be at least one cycle");
      assert (CLK_KHZ >= 1) else $error("pfwp_ctrl: CLK_KHZ must be positive");
   end

   generate
      if (ENFORCE_WINDOWS) begin : g_window_check
         localparam longint WPT_NS_X = longint'(WPT_CYC) * 1000;
         localparam longint KHZ      = longint'(CLK_KHZ);
         initial begin
            assert (WPT_NS_X >= 40 * KHZ && WPT_NS_X <= 150 * KHZ)
               else $error("pfwp_ctrl: write-protect timeout outside 40..150 us");
            assert (longint'(REC_CYC) >= 40 * KHZ && longint'(REC_CYC) <= 120 * KHZ)
               else $error("pfwp_ctrl: recovery window outside 40..120 ms");
         end
      end
   endgenerate

   logic [1:0]  flags_s;
   logic        fail_s, swo_s;
   prot_state_e state;
   logic        drain_wr, host_acc, host_wr, cont;
   strobe_t     host, mem;

   pfwp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pwr_fail, below_swo}),
      .q     (flags_s)
   );

   assign fail_s = flags_s[1];
   assign swo_s  = flags_s[0];
   assign host   = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

   pfwp_sequencer #(.WPT_CYC(WPT_CYC), .REC_CYC(REC_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fail_s   (fail_s),
      .host_acc (host_acc),
      .host_wr  (host_wr),
      .cont     (cont),
      .state    (state),
      .drain_wr (drain_wr)
   );

   pfwp_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .drain_wr (drain_wr),
      .host     (host),
      .mem      (mem),
      .dq_oe    (dq_oe),
      .host_acc (host_acc),
      .host_wr  (host_wr),
      .cont     (cont)
   );

   pfwp_battery u_bat (
      .clk     (clk),
      .rst_n   (rst_n),
      .fail_s  (fail_s),
      .swo_s   (swo_s),
      .bat_sel (bat_sel),
      .bat_iso (bat_iso)
   );

   assign mem_ce_n = mem.ce_n;
   assign mem_we_n = mem.we_n;
   assign mem_oe_n = mem.oe_n;

   // R7: guard and recovery keep the array quiet whatever the host drives
   assert_guard_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_GUARD || state == PS_RECOVER) |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_oe));

   // R4: once a drained access ends, the block is protected on the next edge
   assert_drain_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DRAIN && !cont) |=> (state == PS_GUARD));

endmodule

// File: tb/pfwp_ctrl_test.sv
module pfwp_ctrl_test;

   localparam int WPT = 8;
   localparam int REC = 20;

   logic clk = 1'b0;
   logic rst_n;
   logic pwr_fail, below_swo;
   logic host_ce_n, host_we_n, host_oe_n;
   logic mem_ce_n, mem_we_n, mem_oe_n, dq_oe, bat_sel, bat_iso;

   always #5 clk = ~clk;

   pfwp_ctrl #(
      .WPT_CYC(WPT), .REC_CYC(REC), .SYNC_STAGES(2),
      .CLK_KHZ(100000), .ENFORCE_WINDOWS(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .below_swo(below_swo),
      .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .dq_oe(dq_oe), .bat_sel(bat_sel), .bat_iso(bat_iso)
   );

   typedef struct {
      int         due;
      logic [5:0] vec;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   tests = 0;
   int   fails = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare every expectation due in this cycle at the falling edge
   always @(negedge clk) begin
      logic [5:0] obs;
      obs = {mem_ce_n, mem_we_n, mem_oe_n, dq_oe, bat_sel, bat_iso};
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].due <= cyc) begin
            tests++;
            if (q[i].due < cyc || obs !== q[i].vec) begin
               fails++;
               $display("FAIL %s at cycle %0d: got ce/we/oe/dq/sel/iso=%b expected %b",
                        q[i].tag, cyc, obs, q[i].vec);
            end
            q.delete(i);
         end
      end
   end

   function automatic logic [5:0] v(input logic ce, we, oe, dq, sel, iso);
      return {ce, we, oe, dq, sel, iso};
   endfunction

   task automatic expect_in(input int k, input logic [5:0] vec, input string tag);
      exp_t e;
      e.due = cyc + k;
      e.vec = vec;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_host(input logic ce, we, oe);
      host_ce_n = ce;
      host_we_n = we;
      host_oe_n = oe;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      pwr_fail = 1'b1;
      below_swo = 1'b1;
      set_host(1, 1, 1);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      expect_in(1, v(1,1,1,0,0,1), "R1");
      tick(1);
      // R7 host read ignored while guarded
      set_host(0, 1, 0);
      expect_in(1, v(1,1,1,0,0,1), "R7");
      tick(3);

      // First power-up: isolation release and recovery window (R10, R8)
      pwr_fail = 1'b0;
      below_swo = 1'b0;
      expect_in(2, v(1,1,1,0,0,1), "R10");
      expect_in(3, v(1,1,1,0,0,0), "R10");
      expect_in(10, v(1,1,1,0,0,0), "R7");
      expect_in(2 + REC, v(1,1,1,0,0,0), "R8");
      expect_in(3 + REC, v(0,1,0,1,0,0), "R8");
      tick(4 + REC);

      // R2 decode while open
      set_host(0, 0, 1); expect_in(0, v(0,0,1,0,0,0), "R2"); tick(1);
      set_host(0, 1, 1); expect_in(0, v(0,1,1,0,0,0), "R2"); tick(1);
      set_host(1, 1, 0); expect_in(0, v(1,1,0,0,0,0), "R2"); tick(1);
      set_host(0, 0, 0); expect_in(0, v(0,0,0,0,0,0), "R2"); tick(1);
      set_host(0, 1, 0); expect_in(0, v(0,1,0,1,0,0), "R2"); tick(1);

      // R11 battery select follows the switch-over flag after two edges
      set_host(1, 1, 1);
      below_swo = 1'b1;
      expect_in(1, v(1,1,1,0,0,0), "R11");
      expect_in(2, v(1,1,1,0,1,0), "R11");
      tick(3);
      below_swo = 1'b0;
      expect_in(1, v(1,1,1,0,1,0), "R11");
      expect_in(2, v(1,1,1,0,0,0), "R11");
      tick(3);

      // R3 failure with no access in progress (output disabled only)
      set_host(0, 1, 1);
      pwr_fail = 1'b1;
      expect_in(2, v(0,1,1,0,0,0), "R3");
      expect_in(3, v(1,1,1,0,0,0), "R3");
      tick(4);
      // R7 host strobes ignored; R10 isolation stays released
      set_host(0, 0, 1); expect_in(0, v(1,1,1,0,0,0), "R7"); tick(1);
      set_host(0, 1, 0); expect_in(0, v(1,1,1,0,0,0), "R10"); tick(1);

      set_host(1, 1, 1);
      pwr_fail = 1'b0;
      tick(4 + REC);
      expect_in(0, v(1,1,1,0,0,0), "R8");
      tick(1);

      // R4 and R6: write in flight during failure
      set_host(0, 0, 1);
      tick(1);
      pwr_fail = 1'b1;
      expect_in(3, v(0,0,1,0,0,0), "R4");
      expect_in(5, v(0,0,1,0,0,0), "R4");
      tick(5);
      set_host(0, 0, 0); expect_in(0, v(0,0,1,0,0,0), "R6"); tick(1);
      set_host(0, 1, 0);
      expect_in(0, v(1,1,1,0,0,0), "R4");
      expect_in(1, v(1,1,1,0,0,0), "R6");
      tick(2);
      set_host(0, 0, 1); expect_in(0, v(1,1,1,0,0,0), "R6"); tick(1);

      set_host(1, 1, 1);
      pwr_fail = 1'b0;
      tick(4 + REC);

      // R5 read still running at the timeout is cut off
      set_host(0, 1, 0);
      tick(1);
      pwr_fail = 1'b1;
      expect_in(3, v(0,1,0,1,0,0), "R5");
      expect_in(2 + WPT, v(0,1,0,1,0,0), "R5");
      expect_in(3 + WPT, v(1,1,1,0,0,0), "R5");
      tick(4 + WPT);

      // R9 failure inside the recovery window restarts it
      pwr_fail = 1'b0;
      tick(10);
      pwr_fail = 1'b1;
      tick(5);
      pwr_fail = 1'b0;
      expect_in(2 + REC, v(1,1,1,0,0,0), "R9");
      expect_in(3 + REC, v(0,1,0,1,0,0), "R9");
      tick(4 + REC);

      tick(2);
      if (q.size() != 0) begin
         tests++;
         fails++;
         $display("FAIL pending: %0d expectations left, expected 0", q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule